// File: doc/BRIEF.md
# Load/Store Multiple Transfer Sequencer

This block carries out one 32-bit block load or block store. A start pulse supplies a decoded opcode and the current value of the base register. The block then walks the 16-bit register mask and issues one word access per selected register on a request/ready memory bus. Loaded words go straight to a register-file write port. Store data is fetched through a register-file read port. When the operation ends, the block presents the updated base value on a dedicated writeback port.

Both walking directions are supported, and so are pre- and post-offset addressing. A stored program counter (register 15) is sent out with a fixed offset added. Requests with the privileged S bit are not executed: they finish at once and raise an unsupported flag. Condition evaluation, banked registers and status-register copies are handled elsewhere.

Top module: `lsm_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_req`, `rf_we`, `done`, `wb_en`, `unsup_op` and `busy` are all 0.
- R2: The opcode is decoded as follows. Bits 15:0 are the register mask, where bit i selects register i. Bits 19:16 give the base register index. Bit 20 set means load and clear means store. Bit 21 requests writeback. Bit 22 is the S bit. Bit 23 set means increment and clear means decrement. Bit 24 set means pre-offset. A start is accepted only while `busy` is 0.
- R3: In increment mode, selected registers are accessed in ascending index order, and each access address is 4 above the previous one.
- R4: In decrement mode, selected registers are accessed in descending index order, and each access address is 4 below the previous one.
- R5: The first access address is the base itself when pre-offset is clear. When pre-offset is set, it is base+4 (increment) or base-4 (decrement).
- R6: A store drives `mem_we`=1 and sends the selected register's value as `mem_wdata`. For register 15 the value sent is the register value plus 8.
- R7: A load drives `mem_we`=0. In the cycle where `mem_ready` completes an access, `rf_we` is 1, `rf_waddr` is the register being loaded and `rf_wdata` equals `mem_rdata`. `rf_we` is 0 in every other cycle.
- R8: Exactly one bus access is made per selected register. While `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and the selected register are held unchanged.
- R9: When bit 21 is set and the mask is non-empty, the cycle with `done` also has `wb_en`=1, `wb_idx` equal to bits 19:16, and `wb_val` equal to base+4·n (increment) or base-4·n (decrement), where n is the number of selected registers. Otherwise `wb_en` stays 0.
- R10: `done` is high for exactly one cycle, in the cycle after the final access completes. `busy` is 0 in the cycle after `done`.
- R11: An empty mask produces `done` in the cycle after start, with no bus access and `wb_en`=0.
- R12: With the S bit set, `done` and `unsup_op` are high together in the cycle after start. No bus access is made and `wb_en` is 0.
- R13: `mem_addr[1:0]` is always 0. `wb_val` is computed from the unmasked base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| opcode | input | 32 | Decoded block-transfer opcode |
| base_val | input | 32 | Current base register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| unsup_op | output | 1 | S-bit request rejected (with done) |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data |
| mem_ready | input | 1 | Access completes this cycle |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| wb_en | output | 1 | Base writeback strobe |
| wb_idx | output | 4 | Base register index |
| wb_val | output | 32 | Updated base value |

## Verification
A wrong remaining-mask or picker state shows on the very next accepted beat: the register index or the address differs from what the reference expects, or a bus request appears after the expected beats run out. A corrupted address register or direction flag is visible on `mem_addr` at the same beat. A faulty count or writeback path only shows at the `done` cycle, through `wb_val`, `wb_en` or the cycle in which `done` arrives. The bench compares every cycle against a queue-based model, so any such fault is reported within one cycle of reaching the ports.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  localparam int unsigned OPC_PRE   = 24;
  localparam int unsigned OPC_UP    = 23;
  localparam int unsigned OPC_SBIT  = 22;
  localparam int unsigned OPC_WB    = 21;
  localparam int unsigned OPC_LOAD  = 20;
  localparam int unsigned OPC_RN_LO = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } lsm_state_e;
endpackage

// File: rtl/lsm_pick.sv
module lsm_pick #(
  parameter int unsigned NREG = 16,
  localparam int unsigned IDXW = $clog2(NREG)
) (
  input  logic [NREG-1:0] mask,
  input  logic            up,
  output logic [IDXW-1:0] idx,
  output logic [NREG-1:0] rest
);
  logic [IDXW-1:0] lo_idx, hi_idx;
  logic            lo_found;

  // R3/R4: lowest set bit for ascending walk, highest for descending walk
  always_comb begin
    lo_idx   = '0;
    hi_idx   = '0;
    lo_found = 1'b0;
    for (int i = 0; i < int'(NREG); i++) begin
      if (mask[i] && !lo_found) begin
        lo_idx   = IDXW'(i);
        lo_found = 1'b1;
      end
      if (mask[i]) hi_idx = IDXW'(i);
    end
  end

  assign idx  = up ? lo_idx : hi_idx;
  assign rest = mask & ~(NREG'(1) << idx);
endmodule

// File: rtl/lsm_wbcalc.sv
module lsm_wbcalc #(
  parameter int unsigned NREG = 16,
  parameter int unsigned AW   = 32,
  localparam int unsigned CW  = $clog2(NREG + 1)
) (
  input  logic [NREG-1:0] mask,
  input  logic [AW-1:0]   base,
  input  logic            up,
  input  logic            pre,
  output logic [AW-1:0]   first_addr,
  output logic [AW-1:0]   wb_val
);
  localparam logic [AW-1:0] STEP = AW'(4);

  logic [CW-1:0] cnt;
  logic [AW-1:0] span;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(NREG); i++) cnt = cnt + CW'(mask[i]);
  end

  assign span       = AW'({cnt, 2'b00});
  // R5: first address; R9: updated base
  assign first_addr = pre ? (up ? base + STEP : base - STEP) : base;
  assign wb_val     = up ? base + span : base - span;
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned PC_OFS = 8,
  localparam int unsigned IDXW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     opcode,
  input  logic [AW-1:0]   base_val,
  output logic            busy,
  output logic            done,
  output logic            unsup_op,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ready,
  output logic [IDXW-1:0] rf_raddr,
  input  logic [DW-1:0]   rf_rdata,
  output logic            rf_we,
  output logic [IDXW-1:0] rf_waddr,
  output logic [DW-1:0]   rf_wdata,
  output logic            wb_en,
  output logic [IDXW-1:0] wb_idx,
  output logic [AW-1:0]   wb_val
);
  import lsm_pkg::*;

  localparam logic [AW-1:0]   STEP   = AW'(4);
  localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);

  lsm_state_e      state_q, state_d;
  logic [NREG-1:0] mask_q, mask_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [AW-1:0]   wbv_q;
  logic [IDXW-1:0] rn_q;
  logic            up_q, load_q, wbit_q, sbit_q, nz_q;

  logic            accept, beat;
  logic [IDXW-1:0] pick_idx;
  logic [NREG-1:0] pick_rest;
  logic [AW-1:0]   calc_first, calc_wb;
  logic [NREG-1:0] in_mask;

  assign in_mask = opcode[NREG-1:0];
  assign accept  = (state_q == ST_IDLE) && start;        // R2
  assign beat    = (state_q == ST_XFER) && mem_ready;

  lsm_pick #(.NREG(NREG)) u_pick (
    .mask (mask_q),
    .up   (up_q),
    .idx  (pick_idx),
    .rest (pick_rest)
  );

  lsm_wbcalc #(.NREG(NREG), .AW(AW)) u_calc (
    .mask       (in_mask),
    .base       (base_val),
    .up         (opcode[OPC_UP]),
    .pre        (opcode[OPC_PRE]),
    .first_addr (calc_first),
    .wb_val     (calc_wb)
  );

  // next state
  always_comb begin
    state_d = state_q;
    mask_d  = mask_q;
    addr_d  = addr_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        mask_d = in_mask;
        addr_d = calc_first;
        if (opcode[OPC_SBIT] || (in_mask == '0)) state_d = ST_FIN;  // R11, R12
        else                                     state_d = ST_XFER;
      end
      ST_XFER: if (mem_ready) begin
        mask_d = pick_rest;
        addr_d = up_q ? addr_q + STEP : addr_q - STEP;
        if (pick_rest == '0) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
      rn_q    <= '0;
      up_q    <= 1'b0;
      load_q  <= 1'b0;
      wbit_q  <= 1'b0;
      sbit_q  <= 1'b0;
      nz_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept || beat) begin
        mask_q <= mask_d;
        addr_q <= addr_d;
      end
      if (accept) begin
        wbv_q  <= calc_wb;
        rn_q   <= opcode[OPC_RN_LO +: IDXW];
        up_q   <= opcode[OPC_UP];
        load_q <= opcode[OPC_LOAD];
        wbit_q <= opcode[OPC_WB];
        sbit_q <= opcode[OPC_SBIT];
        nz_q   <= |in_mask;
      end
    end
  end

  // outputs
  assign busy      = (state_q != ST_IDLE);
  assign mem_req   = (state_q == ST_XFER);
  assign mem_we    = !load_q;
  assign mem_addr  = {addr_q[AW-1:2], 2'b00};                  // R13
  assign rf_raddr  = pick_idx;
  assign mem_wdata = (pick_idx == PC_IDX) ? rf_rdata + DW'(PC_OFS) : rf_rdata;  // R6
  assign rf_we     = beat && load_q;                            // R7
  assign rf_waddr  = pick_idx;
  assign rf_wdata  = mem_rdata;
  assign done      = (state_q == ST_FIN);                       // R10
  assign unsup_op  = done && sbit_q;
  assign wb_en     = done && wbit_q && !sbit_q && nz_q;         // R9
  assign wb_idx    = rn_q;
  assign wb_val    = wbv_q;

  // assertions
  a_r8_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(rf_raddr) && $stable(mem_we)));

  // R3 and R4: consecutive beats step by one word in the walking direction
  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready) |=>
      (!mem_req || (mem_addr == (up_q ? $past(mem_addr) + STEP : $past(mem_addr) - STEP))));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  a_r12_unsup_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_op |-> (done && !wb_en && !$past(mem_req)));

  a_r9_wb_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(mem_req && mem_ready));

  a_r7_rf_we_only_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (mem_req && mem_ready && !mem_we));
endmodule

// File: tb/lsm_seq_bench.sv
`timescale 1ns/1ps
module lsm_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] opcode, base_val;
  logic        busy, done, unsup_op, mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, wb_val;
  logic [3:0]  rf_raddr, rf_waddr, wb_idx;
  logic        rf_we, wb_en;

  always #2.5 clk = ~clk;

  lsm_seq u_lsm_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .base_val(base_val),
    .busy(busy), .done(done), .unsup_op(unsup_op),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val)
  );

  typedef struct {
    logic [31:0] addr;
    logic        we;
    logic [3:0]  idx;
    logic [31:0] data;
  } beat_t;

  beat_t       expq[$];
  logic [31:0] regs[16];
  int          checks = 0, errors = 0, cyc = 0;
  int          start_cyc, last_beat_cyc;
  bit          had_beats, done_seen, running, finished;
  bit          exp_wb_en, exp_unsup, exp_up;
  logic [3:0]  exp_wb_idx;
  logic [31:0] exp_wb_val;

  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = ~mem_addr ^ 32'h0F0F_0000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] mk(bit p, bit u, bit s, bit w, bit l, logic [3:0] rn, logic [15:0] m);
    return {7'b0000100, p, u, s, w, l, rn, m};
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // cycle-by-cycle comparison against the queue model
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i * 32'h111);
    end else begin
      mem_ready = mem_req ? ($urandom_range(0, 3) != 0) : 1'b0;
      #1;
      if (running) begin
        if (mem_req) begin
          if (expq.size() == 0) chk(1'b0, "R8 unexpected access", mem_addr, 32'h0);
          else if (mem_ready) begin
            beat_t e;
            e = expq.pop_front();
            had_beats = 1'b1;
            last_beat_cyc = cyc;
            chk(mem_addr == e.addr, exp_up ? "R3 address" : "R4 address", mem_addr, e.addr);
            chk(rf_raddr == e.idx || e.we == 1'b0, exp_up ? "R3 order" : "R4 order", 32'(rf_raddr), 32'(e.idx));
            chk(mem_we == e.we, "R2 direction of access", 32'(mem_we), 32'(e.we));
            if (e.we) chk(mem_wdata == e.data, "R6 store data", mem_wdata, e.data);
            else begin
              chk(rf_we && rf_waddr == e.idx, "R7 load target", {27'b0, rf_we, rf_waddr}, {27'b0, 1'b1, e.idx});
              chk(rf_wdata == e.data, "R7 load data", rf_wdata, e.data);
              regs[e.idx] = rf_wdata;
            end
          end
        end
        if (rf_we && !(mem_req && mem_ready)) chk(1'b0, "R7 stray rf write", 32'(rf_we), 32'h0);
        if (done) begin
          int exp_cyc;
          exp_cyc = had_beats ? last_beat_cyc + 1 : start_cyc + 1;
          chk(expq.size() == 0, "R8 beats missing at done", 32'(expq.size()), 32'h0);
          chk(cyc == exp_cyc, had_beats ? "R10 done timing" : "R11 done timing", 32'(cyc), 32'(exp_cyc));
          chk(wb_en == exp_wb_en, "R9 wb_en", 32'(wb_en), 32'(exp_wb_en));
          if (exp_wb_en) begin
            chk(wb_val == exp_wb_val, "R9 wb_val", wb_val, exp_wb_val);
            chk(wb_idx == exp_wb_idx, "R9 wb_idx", 32'(wb_idx), 32'(exp_wb_idx));
          end
          chk(unsup_op == exp_unsup, "R12 unsup flag", 32'(unsup_op), 32'(exp_unsup));
          done_seen = 1'b1;
        end
      end
    end
  end

  task automatic run_op(input logic [31:0] opc, input logic [31:0] base);
    logic [31:0] a;
    int n;
    @(negedge clk); #2;
    expq.delete();
    had_beats = 1'b0;
    done_seen = 1'b0;
    exp_up    = opc[23];
    exp_unsup = opc[22];
    n = 0;
    for (int i = 0; i < 16; i++) if (opc[i]) n++;
    if (!opc[22]) begin
      a = opc[24] ? (opc[23] ? base + 4 : base - 4) : base;
      for (int k = 0; k < 16; k++) begin
        int i;
        i = opc[23] ? k : 15 - k;
        if (opc[i]) begin
          beat_t e;
          e.addr = {a[31:2], 2'b00};
          e.we   = !opc[20];
          e.idx  = 4'(i);
          e.data = opc[20] ? (~e.addr ^ 32'h0F0F_0000) : (i == 15 ? regs[i] + 8 : regs[i]);
          expq.push_back(e);
          a = opc[23] ? a + 4 : a - 4;
        end
      end
    end
    exp_wb_en  = opc[21] && !opc[22] && (n != 0);
    exp_wb_idx = opc[19:16];
    exp_wb_val = opc[23] ? base + 32'(4 * n) : base - 32'(4 * n);
    chk(!busy, "R2 idle before start", 32'(busy), 32'h0);
    start = 1'b1; opcode = opc; base_val = base; start_cyc = cyc;
    @(negedge clk); #2;
    start = 1'b0;
    for (int t = 0; t < 400 && !done_seen; t++) @(negedge clk);
    chk(done_seen, "R10 done observed", 32'(done_seen), 32'h1);
    @(negedge clk); #2;
    chk(!done && !busy, "R10 single-cycle done", {30'b0, done, busy}, 32'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
    finish_run();
  end

  initial begin
    finished = 1'b0; running = 1'b0;
    rst_n = 1'b0; start = 1'b0; opcode = '0; base_val = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(!mem_req && !rf_we && !done && !wb_en && !unsup_op && !busy, "R1 reset outputs",
        {26'b0, mem_req, rf_we, done, wb_en, unsup_op, busy}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!mem_req && !done && !busy, "R1 after release", {29'b0, mem_req, done, busy}, 32'h0);
    running = 1'b1;
    // R6: store, post-increment, includes register 15
    run_op(mk(0, 1, 0, 1, 0, 4'd2, 16'h8421), 32'h0000_1000);
    // R4 R7: load, pre-decrement
    run_op(mk(1, 0, 0, 1, 1, 4'd13, 16'h00F0), 32'h0000_2000);
    // R5: store, pre-increment, no writeback
    run_op(mk(1, 1, 0, 0, 0, 4'd3, 16'h0C03), 32'h0000_3000);
    // R13: unaligned base, load post-decrement
    run_op(mk(0, 0, 0, 1, 1, 4'd5, 16'h0102), 32'h2000_0013);
    // R11: empty mask with writeback requested
    run_op(mk(1, 1, 0, 1, 1, 4'd1, 16'h0000), 32'h0000_4000);
    // R12: S bit set
    run_op(mk(0, 1, 1, 1, 1, 4'd0, 16'h8001), 32'h0000_5000);
    // R3: full mask load, post-increment
    run_op(mk(0, 1, 0, 1, 1, 4'd14, 16'hFFFF), 32'h0000_6000);
    // R6: full mask store, post-decrement
    run_op(mk(0, 0, 0, 1, 0, 4'd4, 16'hFFFF), 32'h0000_7000);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule